// File: doc/BRIEF.md
# Transport Packet Sync and Error-Flag Inserter

This block frames a byte stream of 204-byte transport packets. Each packet holds a sync byte, 187 payload bytes and 16 check bytes. Bytes arrive on an 8-bit bus, and a valid strobe marks each one. The block finds the packet boundary in one of two ways, chosen by `pulse_mode`:

- **Pulse mode.** An external frame-start pulse forces the boundary, with no flywheel.
- **Sync-word mode.** A tracking state machine hunts for a programmable 8-bit sync code and checks it at the packet distance.

At every boundary it recognises, the block writes a fresh sync byte over the received one. It inverts that byte on every eighth boundary. It copies the upstream error flag into the transport error indicator, which is bit 7 of the second packet byte. It also produces frame-start and first-block markers for the stages downstream.

The tracker has three states:

- **HUNT.** It looks at every byte for the sync code. A match moves it to VERIFY, and the next byte becomes packet position 1.
- **VERIFY.** At each expected boundary, a match counts as a hit. A miss returns the tracker to HUNT. The last required hit moves it to LOCKED.
- **LOCKED.** Each boundary is regenerated. A match clears the miss count, and a miss increments it. The miss that reaches `MISS_LIMIT` returns the tracker to HUNT.

Setting `pulse_mode` forces the tracker to HUNT. A falling edge on `seq_start` arms a sequence restart. The restart takes effect at the next regenerated boundary: that sync byte is inverted and the inversion count starts again.

Top module: `tpsi_inserter`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_fs`, `out_first`, `lock` and `err_status` are all 0.
- R2: In pulse mode, any accepted byte with `frame_pulse` high appears at the output one cycle later as the regenerated sync byte. This is independent of its received value and of its position. A byte without the pulse passes unchanged.
- R3: While `pulse_mode` is 1, `lock`, `out_fs` and `out_first` stay 0 from the next cycle on.
- R4: In sync-word mode, the tracker goes HUNT to VERIFY on a byte equal to `sync_code`. It reaches LOCKED after `LOCK_HITS` (default 2) further matches, each `FRAME_LEN` (204) accepted bytes apart. `lock` rises in the same cycle as the `out_fs` of the byte that completes lock.
- R5: While LOCKED, the byte at each boundary is output as the regenerated sync, even when the received byte differs from `sync_code`.
- R6: The regenerated sync is `~sync_code` on boundary 0, 8, 16 and so on, counted from reset or restart. On every other boundary it is `sync_code`.
- R7: After `MISS_LIMIT` (default 3) consecutive boundary misses, `lock` drops and the tracker returns to HUNT. The missing byte passes unchanged with `out_fs` low. A new sync sequence then relocks after R4's hits.
- R8: `in_err` is sampled only on a boundary byte. If it is high, the next accepted byte is output with bit 7 set. `in_err` on any other byte has no effect.
- R9: `err_status` sets when a boundary byte is accepted with `in_err` high. It then stays set until reset.
- R10: A falling edge on `seq_start` makes the next regenerated boundary `~sync_code`, with `out_first` high. The following boundary is `sync_code`.
- R11: `out_fs` is high for exactly one output byte per boundary, together with `out_valid`. `out_first` is high only together with `out_fs`.
- R12: `sync_code` is programmable. Both matching and regeneration use its current value.
- R13: Cycles with `in_valid` low consume no byte. They give `out_valid` = 0 and do not advance the packet position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pulse_mode | input | 1 | 1 = boundaries forced by `frame_pulse`, 0 = sync-word tracking |
| sync_code | input | 8 | Sync value to match and regenerate |
| in_valid | input | 1 | Input byte strobe |
| in_data | input | 8 | Input byte |
| in_err | input | 1 | Upstream uncorrectable-error flag |
| frame_pulse | input | 1 | Packet start marker (pulse mode) |
| seq_start | input | 1 | Sequence restart request, acts on falling edge |
| out_valid | output | 1 | Output byte strobe |
| out_data | output | 8 | Output byte |
| out_fs | output | 1 | Frame start, one byte wide |
| out_first | output | 1 | First block after a sequence restart |
| lock | output | 1 | Tracker is LOCKED |
| err_status | output | 1 | Sticky error flag seen |

## Verification
The assertions check on every cycle that the markers stay quiet in pulse mode and that `out_first` never appears without `out_fs`. They also check that a frame-start byte always carries the sync code or its complement, that `lock` only rises on a frame-start byte, and that the error status never clears.

Only the directed scenarios can show the cycle counts that the properties cannot see:

- lock after exactly three sync bytes;
- concealment of a corrupted sync;
- the eight-boundary inversion period;
- loss after three misses and relock;
- placement of the error bit on the second byte;
- restart inversion and the forced boundaries of pulse mode.

// File: rtl/tpsi_pkg.sv
package tpsi_pkg;
    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_VERIFY = 2'd1,
        ST_LOCKED = 2'd2
    } trk_state_t;
endpackage

// File: rtl/tpsi_tracker.sv
module tpsi_tracker
    import tpsi_pkg::*;
#(
    parameter int FRAME_LEN  = 204,
    parameter int LOCK_HITS  = 2,
    parameter int MISS_LIMIT = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pulse_mode,
    input  logic       frame_pulse,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic [7:0] sync_code,
    output logic       blk_start,
    output logic       locked
);
    localparam int PW = $clog2(FRAME_LEN);
    localparam int HW = $clog2(LOCK_HITS + 1);
    localparam int MW = $clog2(MISS_LIMIT + 1);
    localparam logic [PW-1:0] POS_LAST  = PW'(FRAME_LEN - 1);
    localparam logic [HW-1:0] HITS_LAST = HW'(LOCK_HITS - 1);
    localparam logic [MW-1:0] MISS_LAST = MW'(MISS_LIMIT - 1);

    trk_state_t    state, state_n;
    logic [PW-1:0] pos, pos_n;
    logic [HW-1:0] hits, hits_n;
    logic [MW-1:0] misses, misses_n;
    logic          regen;
    logic          match, at_bound;

    assign match    = (in_data == sync_code);
    assign at_bound = (pos == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_HUNT;
            pos    <= '0;
            hits   <= '0;
            misses <= '0;
        end else begin
            state  <= state_n;
            pos    <= pos_n;
            hits   <= hits_n;
            misses <= misses_n;
        end
    end

    // transitions
    always_comb begin
        state_n  = state;
        pos_n    = pos;
        hits_n   = hits;
        misses_n = misses;
        regen    = 1'b0;
        if (pulse_mode) begin
            state_n = ST_HUNT;
            regen   = in_valid && frame_pulse;
        end else if (in_valid) begin
            pos_n = (pos == POS_LAST) ? '0 : pos + 1'b1;
            unique case (state)
                ST_HUNT: begin
                    if (match) begin
                        state_n = ST_VERIFY;
                        pos_n   = PW'(1);
                        hits_n  = '0;
                    end
                end
                ST_VERIFY: begin
                    if (at_bound) begin
                        if (!match) begin
                            state_n = ST_HUNT;
                        end else if (hits == HITS_LAST) begin
                            state_n  = ST_LOCKED;
                            misses_n = '0;
                            regen    = 1'b1;
                        end else begin
                            hits_n = hits + 1'b1;
                        end
                    end
                end
                ST_LOCKED: begin
                    if (at_bound) begin
                        if (match) begin
                            misses_n = '0;
                            regen    = 1'b1;
                        end else if (misses == MISS_LAST) begin
                            state_n = ST_HUNT;
                        end else begin
                            misses_n = misses + 1'b1;
                            regen    = 1'b1;
                        end
                    end
                end
                default: state_n = ST_HUNT;
            endcase
        end
    end

    // outputs
    always_comb begin
        blk_start = regen;
        locked    = (state == ST_LOCKED);
    end
endmodule

// File: rtl/tpsi_seq.sv
module tpsi_seq #(
    parameter int INV_PERIOD = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic seq_start,
    input  logic blk_start,
    output logic invert,
    output logic first
);
    localparam int CW = (INV_PERIOD > 1) ? $clog2(INV_PERIOD) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(INV_PERIOD - 1);
    localparam logic [CW-1:0] CNT_ONE  = (INV_PERIOD > 1) ? CW'(1) : '0;

    logic [CW-1:0] cnt;
    logic          ss_prev, pending, fall;

    assign fall   = ss_prev && !seq_start;
    assign invert = pending || (cnt == '0);
    assign first  = pending;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            ss_prev <= 1'b0;
            pending <= 1'b0;
        end else begin
            ss_prev <= seq_start;
            if (blk_start) begin
                cnt     <= pending ? CNT_ONE : ((cnt == CNT_LAST) ? '0 : cnt + 1'b1);
                pending <= fall;
            end else if (fall) begin
                pending <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/tpsi_inserter.sv
module tpsi_inserter #(
    parameter int FRAME_LEN  = 204,
    parameter int LOCK_HITS  = 2,
    parameter int MISS_LIMIT = 3,
    parameter int INV_PERIOD = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pulse_mode,
    input  logic [7:0] sync_code,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_err,
    input  logic       frame_pulse,
    input  logic       seq_start,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_fs,
    output logic       out_first,
    output logic       lock,
    output logic       err_status
);
    logic blk_start, invert, first, err_arm;

    tpsi_tracker #(
        .FRAME_LEN (FRAME_LEN),
        .LOCK_HITS (LOCK_HITS),
        .MISS_LIMIT(MISS_LIMIT)
    ) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .pulse_mode (pulse_mode),
        .frame_pulse(frame_pulse),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .sync_code  (sync_code),
        .blk_start  (blk_start),
        .locked     (lock)
    );

    tpsi_seq #(.INV_PERIOD(INV_PERIOD)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .seq_start(seq_start),
        .blk_start(blk_start),
        .invert   (invert),
        .first    (first)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_data   <= '0;
            out_fs     <= 1'b0;
            out_first  <= 1'b0;
            err_status <= 1'b0;
            err_arm    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_fs    <= blk_start && !pulse_mode;
            out_first <= blk_start && first && !pulse_mode;
            if (blk_start) begin
                out_data <= invert ? ~sync_code : sync_code;
            end else if (in_valid && err_arm) begin
                out_data <= in_data | 8'h80;
            end else begin
                out_data <= in_data;
            end
            if (in_valid) begin
                err_arm <= blk_start && in_err;
            end
            if (blk_start && in_err) begin
                err_status <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/tpsi_inserter_chk.sv
module tpsi_inserter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pulse_mode,
    input logic [7:0] sync_code,
    input logic       out_valid,
    input logic [7:0] out_data,
    input logic       out_fs,
    input logic       out_first,
    input logic       lock,
    input logic       err_status
);
    p_quiet_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_mode |=> (!out_fs && !out_first && !lock));

    p_lock_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock) |-> out_fs);

    p_sync_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_fs |-> (out_data == $past(sync_code) || out_data == ~$past(sync_code)));

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_status |=> err_status);

    p_first_with_fs_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_first |-> (out_fs && out_valid));

    p_fs_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_fs |=> !out_fs);
endmodule

bind tpsi_inserter tpsi_inserter_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pulse_mode(pulse_mode),
    .sync_code (sync_code),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_fs    (out_fs),
    .out_first (out_first),
    .lock      (lock),
    .err_status(err_status)
);

// File: tb/tpsi_inserter_test.sv
`timescale 1ns/1ps
module tpsi_inserter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pulse_mode = 1'b0;
    logic [7:0] sync_code = 8'h47;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_err = 1'b0;
    logic       frame_pulse = 1'b0;
    logic       seq_start = 1'b0;
    logic       out_valid, out_fs, out_first, lock, err_status;
    logic [7:0] out_data;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tpsi_inserter uut (
        .clk(clk), .rst_n(rst_n), .pulse_mode(pulse_mode), .sync_code(sync_code),
        .in_valid(in_valid), .in_data(in_data), .in_err(in_err),
        .frame_pulse(frame_pulse), .seq_start(seq_start),
        .out_valid(out_valid), .out_data(out_data), .out_fs(out_fs),
        .out_first(out_first), .lock(lock), .err_status(err_status)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic send(input logic [7:0] d, input logic e, input logic fp);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_err = e; frame_pulse = fp;
        @(posedge clk); #1;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0; in_err = 1'b0; frame_pulse = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic do_reset(input logic [7:0] code);
        @(negedge clk);
        rst_n = 1'b0; sync_code = code; pulse_mode = 1'b0; seq_start = 1'b0;
        in_valid = 1'b0; in_err = 1'b0; frame_pulse = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(out_valid == 0 && out_fs == 0 && out_first == 0, "R1 markers", {out_valid, out_fs, out_first}, 0);
        chk(lock == 0 && err_status == 0, "R1 lock/err", {lock, err_status}, 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic seq_pulse();
        @(negedge clk); in_valid = 1'b0; seq_start = 1'b1;
        @(negedge clk); seq_start = 1'b0;
        @(posedge clk); #1;
    endtask

    // one 204-byte packet; byte 0 carries rx_sync, the other bytes are 1..60
    task automatic frame(input logic [7:0] rx_sync, input logic err, input logic fp,
                         input logic exp_fs, input logic [7:0] exp_sync, input logic exp_first,
                         input logic exp_lock, input logic exp_flag, input string req);
        send(rx_sync, err, fp);
        chk(out_valid == 1 && out_data == exp_sync, {req, " sync byte"}, out_data, exp_sync);
        chk(out_fs == exp_fs, {req, " fs (R11)"}, out_fs, exp_fs);
        chk(out_first == exp_first, {req, " first (R10)"}, out_first, exp_first);
        chk(lock == exp_lock, {req, " lock"}, lock, exp_lock);
        send(8'h02, 1'b0, 1'b0);
        chk(out_data == (exp_flag ? 8'h82 : 8'h02), "R8 error bit on second byte", out_data,
            exp_flag ? 8'h82 : 8'h02);
        for (int i = 2; i < 204; i++) begin
            send(8'((i % 60) + 1), (i == 5), 1'b0);
            if (i == 6)
                chk(out_data == 8'h07, "R8 error on other byte ignored", out_data, 8'h07);
            if (i == 100) begin
                idle();
                chk(out_valid == 0, "R13 idle gives no output", out_valid, 0);
            end
        end
    endtask

    task automatic t_sync_lock();
        do_reset(8'h47);
        frame(8'h47, 0, 0, 0, 8'h47, 0, 0, 0, "R4 hunt");
        frame(8'h47, 0, 0, 0, 8'h47, 0, 0, 0, "R4 verify");
        frame(8'h47, 0, 0, 1, 8'hB8, 0, 1, 0, "R4 lock, R6 inverted");
        frame(8'h46, 0, 0, 1, 8'h47, 0, 1, 0, "R5 conceal");
        for (int k = 4; k < 10; k++)
            frame(8'h47, 0, 0, 1, 8'h47, 0, 1, 0, "R6 normal");
        chk(err_status == 0, "R9 clear before error", err_status, 0);
        frame(8'h47, 1, 0, 1, 8'hB8, 0, 1, 1, "R6 eighth inverted");
        chk(err_status == 1, "R9 sticky set", err_status, 1);
        frame(8'h00, 0, 0, 1, 8'h47, 0, 1, 0, "R7 miss1");
        frame(8'h00, 0, 0, 1, 8'h47, 0, 1, 0, "R7 miss2");
        frame(8'h00, 0, 0, 0, 8'h00, 0, 0, 0, "R7 loss");
        chk(err_status == 1, "R9 still set", err_status, 1);
        frame(8'h47, 0, 0, 0, 8'h47, 0, 0, 0, "R7 rehunt");
        frame(8'h47, 0, 0, 0, 8'h47, 0, 0, 0, "R7 reverify");
        frame(8'h47, 0, 0, 1, 8'h47, 0, 1, 0, "R7 relock");
    endtask

    task automatic t_restart();
        seq_pulse();
        frame(8'h47, 0, 0, 1, 8'hB8, 1, 1, 0, "R10 restart");
        frame(8'h47, 0, 0, 1, 8'h47, 0, 1, 0, "R10 after restart");
    endtask

    task automatic t_pulse_mode();
        @(negedge clk); pulse_mode = 1'b1;
        seq_pulse();
        chk(lock == 0, "R3 lock low", lock, 0);
        frame(8'h33, 1, 1, 0, 8'hB8, 0, 0, 1, "R2 forced inverted");
        frame(8'h33, 0, 1, 0, 8'h47, 0, 0, 0, "R2 forced normal");
        frame(8'h33, 0, 0, 0, 8'h33, 0, 0, 0, "R2 no pulse passes");
        send(8'h11, 1'b0, 1'b0);
        send(8'h99, 1'b0, 1'b1);
        chk(out_data == 8'h47 && out_fs == 0, "R2 mid-packet pulse", out_data, 8'h47);
        idle();
    endtask

    task automatic t_code();
        do_reset(8'h5A);
        frame(8'h5A, 0, 0, 0, 8'h5A, 0, 0, 0, "R12 hunt");
        frame(8'h5A, 0, 0, 0, 8'h5A, 0, 0, 0, "R12 verify");
        frame(8'h5A, 0, 0, 1, 8'hA5, 0, 1, 0, "R12 lock inverted");
        frame(8'h47, 0, 0, 1, 8'h5A, 0, 1, 0, "R12 regenerated code");
    endtask

    initial begin
        t_sync_lock();
        t_restart();
        t_pulse_mode();
        t_code();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule